// File: doc/BRIEF.md
# Edge-Strobed FIFO Host Port

This block joins a slow, pin-level host to a byte transmitter and a byte receiver through two FIFOs. The host has two asynchronous strobes. A rising edge on the push strobe places the byte on the parallel input into a 16-entry transmit queue. A rising edge on the pop strobe takes the oldest byte from a 16-entry receive queue and holds it on the parallel output. Each strobe passes through a two-flop synchronizer and a rising-edge detector, so one edge moves exactly one byte however long the strobe stays high.

A small loader state machine drains the transmit queue into the transmitter through a valid/ready pair. It presents one byte at a time and keeps it steady until the transmitter accepts it. Bytes from the receiver arrive as one-cycle valid pulses and are written into the receive queue. A byte that arrives while that queue is full is dropped, and a one-cycle overflow pulse reports the loss. The bytes already queued are kept. The host sees a transmit-full flag and a receive-empty flag.

Top module: `strobe_fifo_port`

## Requirements
- R1: Each rising edge of `push_strobe_i` enqueues exactly one byte, taken from `host_data_i` on the third clock edge after the strobe is first sampled high, whatever the strobe's width; the byte later reaches the transmitter unchanged.
- R2: Each rising edge of `pop_strobe_i` dequeues exactly one byte, whatever the strobe's width. `host_data_o` keeps its old value through the third clock edge after the strobe is first sampled high, shows the popped byte from the fourth edge, and holds it until the next successful pop.
- R3: A strobe that is already high when reset is released acts as one rising edge, and no further byte moves until it has gone low and risen again.
- R4: The transmit path holds 16 queued bytes plus the one byte being presented. `tx_full_o` is 1 exactly while 16 bytes are queued. A push while it is 1 is ignored, and the flag stays 1 until the loader removes a byte.
- R5: The loader raises `xmit_valid_o` with a byte on `xmit_data_o` and keeps both unchanged until a clock edge where `xmit_ready_i` is 1. Bytes leave in the order they were pushed.
- R6: A byte offered on `recv_valid_i` while the receive queue holds 16 bytes is dropped. `rx_overflow_o` is 1 for exactly the one cycle after that edge, and the 16 held bytes still pop out in arrival order.
- R7: A pop while the receive queue is empty leaves `host_data_o` and `rx_empty_o` unchanged, and it does not consume a byte that arrives later.
- R8: A synchronous active-high `rst` empties both queues (`rx_empty_o`=1, `tx_full_o`=0), clears `host_data_o` to 0, drops `xmit_valid_o` and `rx_overflow_o`, and returns the loader to idle.
- R9: `rx_empty_o` is 0 while the receive queue holds any byte and returns to 1 once the last byte has been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data_i | input | 8 | Parallel byte to enqueue on a push edge |
| push_strobe_i | input | 1 | Asynchronous push strobe, acted on at its rising edge |
| pop_strobe_i | input | 1 | Asynchronous pop strobe, acted on at its rising edge |
| host_data_o | output | 8 | Last popped byte, held until the next pop |
| tx_full_o | output | 1 | Transmit queue holds 16 bytes |
| rx_empty_o | output | 1 | Receive queue holds no byte |
| rx_overflow_o | output | 1 | One-cycle pulse after a received byte was dropped |
| xmit_data_o | output | 8 | Byte offered to the transmitter |
| xmit_valid_o | output | 1 | Offered byte is valid |
| xmit_ready_i | input | 1 | Transmitter accepts the offered byte |
| recv_data_i | input | 8 | Byte from the receiver |
| recv_valid_i | input | 1 | Receiver byte is valid this cycle |

## Verification
Counting from the first clock edge at which a strobe is sampled high, a push is written into the queue on the third edge. A pop's byte reaches `host_data_o` on the fourth edge. An overflow pulse appears at the edge that sees the dropped byte and lasts one cycle. The bench drives and samples on falling edges. For every pop it checks the old value after the third rising edge and the new value after the fourth. It checks the overflow flag on the first and second falling edges after the offending byte. Transfers to the transmitter are logged on the falling edge before the rising edge where valid and ready meet. Queue-level results are read only after a settle window longer than the loader's three-cycle turn per byte.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // loader sequencing: read request, data capture, offer to transmitter
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_OFFER = 2'd2
  } ld_state_e;

endpackage

// File: rtl/sfp_edge_sync.sv
module sfp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain;
  logic              last;

  // history cleared in reset: a level already high at release reads as one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      last  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~last;

endmodule

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full_o,
  output logic             empty_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             full_q, empty_q;
  logic             do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign do_wr = wr_en & ~full_q;
  assign do_rd = rd_en & ~empty_q;

  always_comb begin
    case ({do_wr, do_rd})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  // storage without reset and with a registered read port, RAM-friendly
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      cnt     <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
    end
  end

  assign full_o  = full_q;
  assign empty_o = empty_q;

endmodule

// File: rtl/sfp_loader.sv
module sfp_loader
  import sfp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_empty_i,
  output logic             fifo_rd_o,
  input  logic [WIDTH-1:0] fifo_data_i,
  input  logic             xmit_ready_i,
  output logic             xmit_valid_o,
  output logic [WIDTH-1:0] xmit_data_o
);

  ld_state_e state;

  assign fifo_rd_o = (state == LD_IDLE) && !fifo_empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= LD_IDLE;
      xmit_valid_o <= 1'b0;
      xmit_data_o  <= '0;
    end else begin
      case (state)
        LD_IDLE: begin
          if (fifo_rd_o) state <= LD_FETCH;
        end
        LD_FETCH: begin
          xmit_data_o  <= fifo_data_i;
          xmit_valid_o <= 1'b1;
          state        <= LD_OFFER;
        end
        LD_OFFER: begin
          if (xmit_ready_i) begin
            xmit_valid_o <= 1'b0;
            state        <= LD_IDLE;
          end
        end
        default: begin
          xmit_valid_o <= 1'b0;
          state        <= LD_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/strobe_fifo_port.sv
module strobe_fifo_port #(
  parameter int DATA_W     = 8,
  parameter int TX_DEPTH   = 16,
  parameter int RX_DEPTH   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              push_strobe_i,
  input  logic              pop_strobe_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              tx_full_o,
  output logic              rx_empty_o,
  output logic              rx_overflow_o,
  output logic [DATA_W-1:0] xmit_data_o,
  output logic              xmit_valid_o,
  input  logic              xmit_ready_i,
  input  logic [DATA_W-1:0] recv_data_i,
  input  logic              recv_valid_i
);

  logic              push_rise, pop_rise;
  logic              tx_rd, tx_empty;
  logic [DATA_W-1:0] tx_rd_data;
  logic              rx_full;
  logic [DATA_W-1:0] rx_rd_data;
  logic              pop_take, pop_pend;

  sfp_edge_sync #(.STAGES(SYNC_STAGES)) u_push_sync (
    .clk(clk), .rst(rst), .async_i(push_strobe_i), .rise_o(push_rise)
  );

  sfp_edge_sync #(.STAGES(SYNC_STAGES)) u_pop_sync (
    .clk(clk), .rst(rst), .async_i(pop_strobe_i), .rise_o(pop_rise)
  );

  // transmit side: host byte sampled on the edge where the push edge is seen
  sfp_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst(rst),
    .wr_en(push_rise), .wr_data(host_data_i),
    .rd_en(tx_rd), .rd_data(tx_rd_data),
    .full_o(tx_full_o), .empty_o(tx_empty)
  );

  sfp_loader #(.WIDTH(DATA_W)) u_loader (
    .clk(clk), .rst(rst),
    .fifo_empty_i(tx_empty), .fifo_rd_o(tx_rd), .fifo_data_i(tx_rd_data),
    .xmit_ready_i(xmit_ready_i), .xmit_valid_o(xmit_valid_o),
    .xmit_data_o(xmit_data_o)
  );

  // receive side: queue refuses writes when full, the drop is reported
  sfp_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst(rst),
    .wr_en(recv_valid_i), .wr_data(recv_data_i),
    .rd_en(pop_rise), .rd_data(rx_rd_data),
    .full_o(rx_full), .empty_o(rx_empty_o)
  );

  assign pop_take = pop_rise & ~rx_empty_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_pend      <= 1'b0;
      host_data_o   <= '0;
      rx_overflow_o <= 1'b0;
    end else begin
      pop_pend      <= pop_take;
      rx_overflow_o <= recv_valid_i & rx_full;
      if (pop_pend) host_data_o <= rx_rd_data;
    end
  end

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              push_strobe_i,
  input logic              pop_strobe_i,
  input logic [DATA_W-1:0] host_data_o,
  input logic              tx_full_o,
  input logic              rx_empty_o,
  input logic              rx_overflow_o,
  input logic [DATA_W-1:0] xmit_data_o,
  input logic              xmit_valid_o,
  input logic              xmit_ready_i,
  input logic              recv_valid_i
);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!xmit_valid_o && rx_empty_o && !tx_full_o &&
             host_data_o == '0 && !rx_overflow_o));

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xmit_valid_o && !xmit_ready_i) |=> (xmit_valid_o && $stable(xmit_data_o)));

  // R6
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overflow_o |-> ($past(recv_valid_i) && !$past(rx_empty_o)));

  // R4
  full_from_push_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full_o) |-> $past(push_strobe_i, 3));

  // R2
  output_from_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(host_data_o) |-> $past(pop_strobe_i, 4));

endmodule

bind strobe_fifo_port sfp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .push_strobe_i(push_strobe_i), .pop_strobe_i(pop_strobe_i),
  .host_data_o(host_data_o), .tx_full_o(tx_full_o), .rx_empty_o(rx_empty_o),
  .rx_overflow_o(rx_overflow_o), .xmit_data_o(xmit_data_o),
  .xmit_valid_o(xmit_valid_o), .xmit_ready_i(xmit_ready_i),
  .recv_valid_i(recv_valid_i)
);

// File: tb/sim_strobe_fifo_port.sv
`timescale 1ns/1ps
module sim_strobe_fifo_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] host_data_i = 8'h00;
  logic       push_strobe_i = 1'b0;
  logic       pop_strobe_i = 1'b0;
  logic [7:0] host_data_o;
  logic       tx_full_o, rx_empty_o, rx_overflow_o;
  logic [7:0] xmit_data_o;
  logic       xmit_valid_o;
  logic       xmit_ready_i = 1'b1;
  logic [7:0] recv_data_i = 8'h00;
  logic       recv_valid_i = 1'b0;

  always #2.5 clk = ~clk;

  strobe_fifo_port u0 (
    .clk(clk), .rst(rst), .host_data_i(host_data_i),
    .push_strobe_i(push_strobe_i), .pop_strobe_i(pop_strobe_i),
    .host_data_o(host_data_o), .tx_full_o(tx_full_o), .rx_empty_o(rx_empty_o),
    .rx_overflow_o(rx_overflow_o), .xmit_data_o(xmit_data_o),
    .xmit_valid_o(xmit_valid_o), .xmit_ready_i(xmit_ready_i),
    .recv_data_i(recv_data_i), .recv_valid_i(recv_valid_i)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] txlog [64];
  int txn = 0;

  // transmitter model: a transfer happens at the rising edge after this sample
  always @(negedge clk) begin
    if (!rst && xmit_valid_o && xmit_ready_i) begin
      if (txn < 64) txlog[txn] = xmit_data_o;
      txn = txn + 1;
    end
  end

  // {byte, strobe width in cycles}
  localparam logic [15:0] VEC [6] = '{
    16'h3C_01, 16'hA5_02, 16'h00_07, 16'hFF_03, 16'h81_0C, 16'h5A_01
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input int w);
    @(negedge clk);
    host_data_i   = d;
    push_strobe_i = 1'b1;
    repeat (w) @(negedge clk);
    push_strobe_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic recv(input logic [7:0] d);
    @(negedge clk);
    recv_data_i  = d;
    recv_valid_i = 1'b1;
    @(negedge clk);
    recv_valid_i = 1'b0;
  endtask

  // R2 timing: old value after 3rd rising edge, new value after the 4th
  task automatic pop_check(input logic [7:0] exp, input int w, input string req);
    logic [7:0] old;
    old = host_data_o;
    @(negedge clk);
    pop_strobe_i = 1'b1;
    for (int k = 1; k <= w + 6; k++) begin
      @(negedge clk);
      if (k == w) pop_strobe_i = 1'b0;
      if (k == 3) chk({req, " held before 4th edge"}, host_data_o, old);
      if (k == 4) chk({req, " popped byte at 4th edge"}, host_data_o, exp);
    end
    chk({req, " popped byte held"}, host_data_o, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n0;
    // R8 reset state
    cyc(4);
    chk("R8 rx_empty", rx_empty_o, 1);
    chk("R8 tx_full", tx_full_o, 0);
    chk("R8 host_data", host_data_o, 0);
    chk("R8 xmit_valid", xmit_valid_o, 0);
    chk("R8 overflow", rx_overflow_o, 0);
    rst = 1'b0;
    cyc(4);

    // R1 / R2 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      int w;
      d  = VEC[i][15:8];
      w  = int'(VEC[i][7:0]);
      n0 = txn;
      push(d, w);
      cyc(8);
      chk("R1 one byte per push edge", txn, n0 + 1);
      chk("R1 byte reaches transmitter", txlog[n0], d);
      recv(d ^ 8'hC3);
      cyc(2);
      chk("R9 rx_empty low with data", rx_empty_o, 0);
      pop_check(d ^ 8'hC3, w, "R2");
      chk("R9 rx_empty after last pop", rx_empty_o, 1);
    end

    // R7 pop on empty
    pop_check(8'h99, 1, "R7 empty pop");
    chk("R7 rx_empty unchanged", rx_empty_o, 1);
    recv(8'h42);
    cyc(3);
    pop_check(8'h42, 2, "R7 later byte not consumed");

    // R4 / R5 stalled transmitter
    xmit_ready_i = 1'b0;
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 2);
    chk("R4 not full at 16 pushed", tx_full_o, 0);
    push(8'h20, 2);
    chk("R4 full at 17 pushed", tx_full_o, 1);
    chk("R5 valid while stalled", xmit_valid_o, 1);
    chk("R5 first byte offered", xmit_data_o, 8'h10);
    push(8'hEE, 3);
    cyc(20);
    chk("R4 full stays while stalled", tx_full_o, 1);
    chk("R5 data held while stalled", xmit_data_o, 8'h10);
    n0 = txn;
    xmit_ready_i = 1'b1;
    cyc(100);
    chk("R4 push while full ignored", txn, n0 + 17);
    for (int i = 0; i < 17; i++)
      chk("R5 order preserved", txlog[n0 + i], 8'h10 + 8'(i));
    chk("R4 full clears", tx_full_o, 0);

    // R6 receive overflow
    for (int i = 0; i < 16; i++) recv(8'h60 + 8'(i));
    chk("R6 no overflow below full", rx_overflow_o, 0);
    @(negedge clk);
    recv_data_i  = 8'hDD;
    recv_valid_i = 1'b1;
    @(negedge clk);
    recv_valid_i = 1'b0;
    chk("R6 overflow pulse", rx_overflow_o, 1);
    @(negedge clk);
    chk("R6 overflow one cycle", rx_overflow_o, 0);
    for (int i = 0; i < 16; i++) pop_check(8'h60 + 8'(i), 1, "R6 drain order");
    chk("R6 dropped byte absent", rx_empty_o, 1);

    // R3 strobes high across reset release
    @(negedge clk);
    rst           = 1'b1;
    host_data_i   = 8'h77;
    push_strobe_i = 1'b1;
    pop_strobe_i  = 1'b1;
    cyc(4);
    chk("R8 mid-run reset host_data", host_data_o, 0);
    chk("R8 mid-run reset rx_empty", rx_empty_o, 1);
    n0 = txn;
    rst          = 1'b0;
    recv_data_i  = 8'h2B;
    recv_valid_i = 1'b1;
    @(negedge clk);
    recv_valid_i = 1'b0;
    cyc(12);
    chk("R3 pop high at release pops once", host_data_o, 8'h2B);
    chk("R3 push high at release pushes once", txn, n0 + 1);
    chk("R3 pushed byte", txlog[n0], 8'h77);
    recv(8'h3D);
    cyc(10);
    chk("R3 held pop moves no more", rx_empty_o, 0);
    chk("R3 held pop output kept", host_data_o, 8'h2B);
    chk("R3 held push moves no more", txn, n0 + 1);
    push_strobe_i = 1'b0;
    pop_strobe_i  = 1'b0;
    cyc(5);

    finish_run();
  end

endmodule